// File: doc/BRIEF.md
# Dual-Threshold Supply Droop Clamp

This block sits at the end of an on-die supply-noise estimator. Each clock it takes a signed estimate of how far the local supply voltage has moved from nominal and compares it with two programmable limits. If the estimate is under the low limit, the supply is sagging, so the block raises a throttle request. The pipeline answers by gating clocks or by holding fetch or issue, which lowers current draw. If the estimate is over the high limit, the supply is overshooting, so the block raises a force-on request. That request turns on idle units that would otherwise be clock-gated, which raises current draw. Inside the band between the two limits, neither request is raised.

Each side of the clamp has its own enable. Software can therefore run it with only the low side, only the high side, both sides, or neither. The two requests are registered, so the control loop adds exactly one clock of delay. Two saturating counters record how many clocks each request was active, so the clamp's activity can be measured over a run.

Top module: `didt_clamp`

## Requirements
- R1: When `lo_en` is 1 and `v_est` is strictly less than `thr_lo` (signed two's-complement compare) at a rising edge, `throttle` is 1 after that edge. Otherwise `throttle` is 0 after that edge.
- R2: When `hi_en` is 1, `v_est` is strictly greater than `thr_hi` (signed compare), and R1 does not call for throttle, `force_on` is 1 after that edge. Otherwise `force_on` is 0 after that edge.
- R3: An estimate equal to `thr_lo` or equal to `thr_hi` counts as inside the band and raises neither request.
- R4: An estimate strictly between the two limits raises neither request, whatever the enables are.
- R5: A side whose enable is 0 never asserts its request, even when the estimate is far past that side's limit.
- R6: `throttle` and `force_on` are never 1 in the same clock. When `thr_lo` > `thr_hi` and both conditions hold, `throttle` wins.
- R7: Each request depends only on the inputs sampled at the edge just before it, with exactly one register of delay. A one-clock excursion gives a one-clock pulse.
- R8: `thr_cnt` starts at 0 and rises by one for each clock in which `throttle` is 1. It holds at its all-ones value, 2^CW-1, once it reaches it.
- R9: `frc_cnt` behaves the same way for `force_on`, including the hold at 2^CW-1.
- R10: While `rst_n` is 0, both requests and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| v_est | input | VW | Signed estimate of supply deviation |
| thr_lo | input | VW | Signed low limit |
| thr_hi | input | VW | Signed high limit |
| lo_en | input | 1 | Enables the low (throttle) side |
| hi_en | input | 1 | Enables the high (force-on) side |
| throttle | output | 1 | Request to reduce activity |
| force_on | output | 1 | Request to turn on idle units |
| thr_cnt | output | CW | Saturating count of throttle clocks |
| frc_cnt | output | CW | Saturating count of force-on clocks |

## Verification
The random stimulus uses a narrow value range, so the estimate often lands exactly on a limit. An unsigned compare, or a non-strict one, would then raise a request at the boundary or near zero. Directed cases use inverted limits: a design without the throttle priority would assert both requests at once. Other directed cases disable one side while driving far past its limit, and use one-clock excursions to catch an extra pipeline stage. Long runs of one request hit the counter ceiling, where a design without saturation would wrap back to zero.

// File: rtl/didt_clamp.sv
module didt_clamp #(
  parameter int VW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [VW-1:0] v_est,
  input  logic signed [VW-1:0] thr_lo,
  input  logic signed [VW-1:0] thr_hi,
  input  logic                 lo_en,
  input  logic                 hi_en,
  output logic                 throttle,
  output logic                 force_on,
  output logic [CW-1:0]        thr_cnt,
  output logic [CW-1:0]        frc_cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic sag, surge, thr_nx, frc_nx;

  assign sag    = lo_en && (v_est < thr_lo);
  assign surge  = hi_en && (v_est > thr_hi);
  assign thr_nx = sag;
  assign frc_nx = surge && !sag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      throttle <= 1'b0;
      force_on <= 1'b0;
      thr_cnt  <= '0;
      frc_cnt  <= '0;
    end else begin
      throttle <= thr_nx;
      force_on <= frc_nx;
      if (thr_nx && thr_cnt != CNT_MAX) thr_cnt <= thr_cnt + 1'b1;
      if (frc_nx && frc_cnt != CNT_MAX) frc_cnt <= frc_cnt + 1'b1;
    end
  end

  // R6
  mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(throttle && force_on));

  // R5
  lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_en |=> !throttle);

  // R5
  hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> !force_on);

  // R8
  thr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_cnt == CNT_MAX |=> thr_cnt == CNT_MAX);

  // R9
  frc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_cnt == CNT_MAX |=> frc_cnt == CNT_MAX);

  // R8
  thr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!throttle && thr_cnt != CNT_MAX) |=> thr_cnt == $past(thr_cnt) + CW'(throttle));

  // R3
  band_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_est == thr_lo && v_est == thr_hi) |=> !throttle && !force_on);
endmodule

// File: tb/tb_didt_clamp.sv
module tb_didt_clamp;
  localparam int VW = 16;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [VW-1:0] v_est = '0, thr_lo = '0, thr_hi = '0;
  logic lo_en = 1'b0, hi_en = 1'b0;
  logic throttle, force_on;
  logic [CW-1:0] thr_cnt, frc_cnt;

  int errors = 0, checks = 0;
  int m_thr = 0, m_frc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  didt_clamp #(.VW(VW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .v_est(v_est), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .lo_en(lo_en), .hi_en(hi_en), .throttle(throttle), .force_on(force_on),
    .thr_cnt(thr_cnt), .frc_cnt(frc_cnt));

  function automatic bit want_thr(int v, int lo, bit le);
    return le && (v < lo);
  endfunction

  function automatic bit want_frc(int v, int lo, int hi, bit le, bit he);
    return he && (v > hi) && !(le && (v < lo));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int v, int lo, int hi, bit le, bit he,
                      string rt, string rf);
    bit et, ef;
    v_est = VW'(v); thr_lo = VW'(lo); thr_hi = VW'(hi);
    lo_en = le; hi_en = he;
    et = want_thr(v, lo, le);
    ef = want_frc(v, lo, hi, le, he);
    @(negedge clk);
    if (et && m_thr < CMAX) m_thr++;
    if (ef && m_frc < CMAX) m_frc++;
    check(rt, int'(throttle), int'(et));
    check(rf, int'(force_on), int'(ef));
    check("R8", int'(thr_cnt), m_thr);
    check("R9", int'(frc_cnt), m_frc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    v_est = -16'sd50; thr_lo = 16'sd0; lo_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", int'(throttle), 0);
    check("R10", int'(force_on), 0);
    check("R10", int'(thr_cnt), 0);
    check("R10", int'(frc_cnt), 0);
    rst_n = 1'b1;

    step(-3, -3, 3, 1, 1, "R3", "R3");
    step(3, -3, 3, 1, 1, "R3", "R3");
    step(0, -3, 3, 1, 1, "R4", "R4");
    step(-4, -3, 3, 1, 1, "R1", "R2");
    step(4, -3, 3, 1, 1, "R1", "R2");
    step(-1000, -3, 3, 0, 1, "R5", "R5");
    step(1000, -3, 3, 1, 0, "R5", "R5");
    step(5, 10, 0, 1, 1, "R6", "R6");
    step(5, 10, 0, 0, 1, "R6", "R6");
    step(0, 0, 0, 1, 1, "R7", "R7");
    step(-1, 0, 0, 1, 1, "R7", "R7");
    step(0, 0, 0, 1, 1, "R7", "R7");
    step(1, 0, 0, 1, 1, "R7", "R7");
    step(0, 0, 0, 1, 1, "R7", "R7");
    step(-32768, -32767, 32766, 1, 1, "R1", "R2");
    step(32767, -32767, 32766, 1, 1, "R1", "R2");

    for (int i = 0; i < 300; i++) begin
      int v, lo, hi;
      v  = int'($urandom_range(15)) - 8;
      lo = int'($urandom_range(15)) - 8;
      hi = int'($urandom_range(15)) - 8;
      step(v, lo, hi, 1'($urandom_range(1)), 1'($urandom_range(1)), "R1", "R2");
    end

    for (int i = 0; i < CMAX + 6; i++) step(-9, 0, 5, 1, 1, "R1", "R8");
    for (int i = 0; i < CMAX + 6; i++) step(9, 0, 5, 1, 1, "R9", "R2");
    check("R8", int'(thr_cnt), CMAX);
    check("R9", int'(frc_cnt), CMAX);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule